// File: doc/BRIEF.md
# Monochrome Graphic LCD Frame Buffer Scanner

This block refreshes a monochrome passive-matrix graphic panel from an on-chip frame buffer. A processor fills the buffer through a small memory-mapped slave port with a one-cycle read latency. A second, independent read port belongs to a scan sequencer that walks the buffer without pause. The sequencer presents four pixels at a time on a 4-bit data bus, together with a pixel clock, a line sync that marks the last nibble of each row and a frame sync that marks the first row.

Everything runs on one system clock at eight times the pixel clock. A 3-bit phase counter produces one-cycle enables, and no divided clocks are used. Phase 0 steps the column and row counters. Phase 1 fetches the buffer byte. Phase 2 loads the data and sync pins. Phases 0 and 4 set and clear the outgoing pixel clock. Panel width (in pixels) and height (in rows) are parameters. The column count is width/4, with a floor of one column, so a very narrow setting becomes a single-column line instead of a counter that never moves.

Top module: `lcd_scan_fb`

## Requirements
- R1: With `rst` high at a clock edge, every output of the display side (`pclk_o`, `data_o`, `lsync_o`, `fsync_o`) and `cpu_rdata` is low after that edge. The first nibble shown after reset is nibble index 0.
- R2: Counting the edges after reset release as P0, P1, and so on, `pclk_o` is high after edges P(8j)..P(8j+3) and low after P(8j+4)..P(8j+7). This gives a 50% duty cycle at one eighth of the clock rate.
- R3: Nibble k of the stream is shown on `data_o` from edge P(8k+2) up to and including P(8k+9). It is the nibble with index k modulo (COLS*ROWS), and `data_o` changes only while `pclk_o` is high.
- R4: Nibble index n = row*COLS + col is stored in buffer byte n/2, in bits [3:0] when n is even and in bits [7:4] when n is odd. COLS = max(1, width/4).
- R5: The column steps 0..COLS-1 and the row advances only after the last column. After row ROWS-1 the scan wraps to nibble index 0.
- R6: `lsync_o` is high exactly while `data_o` carries a last-column nibble.
- R7: `fsync_o` is high exactly while `data_o` carries a nibble from row 0.
- R8: A read strobe at an edge puts the addressed byte on `cpu_rdata` after that edge. Without a read strobe, `cpu_rdata` holds its value.
- R9: A write strobe stores `cpu_wdata` at `cpu_addr`. A read and a write to the same address at the same edge return the old byte, and a later read returns the new one.
- R10: A byte written through the slave port appears on `data_o` no later than the next full frame.
- R11: When width/4 is 1 (or less), each row is one nibble and `lsync_o` is high for every nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, eight times the pixel rate |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | AW | Byte address of the slave port |
| cpu_wdata | input | 8 | Write data of the slave port |
| cpu_we | input | 1 | Write strobe |
| cpu_re | input | 1 | Read strobe |
| cpu_rdata | output | 8 | Read data, one cycle after the strobe |
| pclk_o | output | 1 | Pixel clock to the panel |
| data_o | output | 4 | Four pixels per pixel clock |
| lsync_o | output | 1 | High during the last nibble of each row |
| fsync_o | output | 1 | High during the nibbles of row 0 |

## Verification
A phase counter that slips or skips moves the pixel-clock edges against the data change, and this shows up within a single eight-cycle pixel period. A column counter that miscounts or wraps at the wrong value puts a wrong nibble on the pins at the next phase-2 load, and it mistimes `lsync_o` by the end of the first row. A row counter or frame wrap fault only shows when the first row ends or a frame restarts, so the sweep covers at least two whole frames. A fault in nibble selection or slave-port latency shows at the first odd nibble, or one cycle after the first read.

// File: rtl/lcd_scan_fb.sv
module lcd_scan_fb #(
  parameter int SCR_W = 16,
  parameter int SCR_H = 4,
  localparam int COLS  = (SCR_W / 4 < 1) ? 1 : SCR_W / 4,
  localparam int ROWS  = (SCR_H < 1) ? 1 : SCR_H,
  localparam int NIBS  = COLS * ROWS,
  localparam int BYTES = (NIBS + 1) / 2,
  localparam int AW    = (BYTES > 1) ? $clog2(BYTES) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] cpu_addr,
  input  logic [7:0]    cpu_wdata,
  input  logic          cpu_we,
  input  logic          cpu_re,
  output logic [7:0]    cpu_rdata,
  output logic          pclk_o,
  output logic [3:0]    data_o,
  output logic          lsync_o,
  output logic          fsync_o
);
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1;
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int NW = (NIBS > 1) ? $clog2(NIBS) : 1;

  logic [7:0]    mem [BYTES];
  logic [2:0]    ph;
  logic          armed;
  logic [CW-1:0] col;
  logic [RW-1:0] row;
  logic [7:0]    scan_q;
  logic [NW-1:0] nib;
  logic [AW-1:0] baddr;

  wire col_last = (col == CW'(COLS - 1));
  wire row_last = (row == RW'(ROWS - 1));
  wire adv      = (ph == 3'd0) && armed;

  assign nib   = NW'(row * COLS + col);
  assign baddr = AW'(nib >> 1);

  always_ff @(posedge clk) begin
    if (cpu_we) mem[cpu_addr] <= cpu_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)         cpu_rdata <= '0;
    else if (cpu_re) cpu_rdata <= mem[cpu_addr];
  end

  always_ff @(posedge clk) begin
    if (ph == 3'd1) scan_q <= mem[baddr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph      <= '0;
      armed   <= 1'b0;
      col     <= '0;
      row     <= '0;
      pclk_o  <= 1'b0;
      data_o  <= '0;
      lsync_o <= 1'b0;
      fsync_o <= 1'b0;
    end else begin
      ph <= ph + 3'd1;
      if (ph == 3'd7) armed <= 1'b1;
      if (ph == 3'd0)      pclk_o <= 1'b1;
      else if (ph == 3'd4) pclk_o <= 1'b0;
      if (adv) begin
        if (col_last) begin
          col <= '0;
          row <= row_last ? '0 : row + RW'(1);
        end else begin
          col <= col + CW'(1);
        end
      end
      if (ph == 3'd2) begin
        data_o  <= nib[0] ? scan_q[7:4] : scan_q[3:0];
        lsync_o <= col_last;
        fsync_o <= (row == '0);
      end
    end
  end
endmodule

module lcd_scan_fb_chk (
  input logic       clk,
  input logic       rst,
  input logic       cpu_re,
  input logic [7:0] cpu_rdata,
  input logic       pclk_o,
  input logic [3:0] data_o,
  input logic       lsync_o,
  input logic       fsync_o
);
  logic       pq;
  logic       seen;
  logic [3:0] gap;
  wire toggled = (pclk_o != pq);

  always_ff @(posedge clk) begin
    if (rst) begin
      pq   <= 1'b0;
      seen <= 1'b0;
      gap  <= '0;
    end else begin
      pq <= pclk_o;
      if (toggled) begin
        gap  <= '0;
        seen <= 1'b1;
      end else if (gap != 4'hF) begin
        gap <= gap + 4'd1;
      end
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!pclk_o && data_o == 4'd0 && !lsync_o && !fsync_o && cpu_rdata == 8'd0));

  assert_pclk_half_R2: assert property (@(posedge clk) disable iff (rst)
    (seen && toggled) |-> (gap == 4'd3));

  assert_data_window_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(data_o) |-> pclk_o);

  assert_lsync_window_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(lsync_o) |-> pclk_o);

  assert_fsync_window_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(fsync_o) |-> pclk_o);

  assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(cpu_re) |-> $stable(cpu_rdata));
endmodule

bind lcd_scan_fb lcd_scan_fb_chk u_chk (.*);

// File: tb/lcd_scan_fb_bench.sv
module lcd_scan_fb_bench;
  localparam int ACOLS = 4, AROWS = 4, ANIB = 16, ABYTES = 8;
  localparam int BCOLS = 1, BROWS = 3, BNIB = 3, BBYTES = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [2:0] a_addr = '0;
  logic [7:0] a_wdata = '0;
  logic       a_we = 1'b0, a_re = 1'b0;
  logic [7:0] a_rdata;
  logic       a_pclk, a_ls, a_fs;
  logic [3:0] a_data;

  logic [0:0] b_addr = '0;
  logic [7:0] b_wdata = '0;
  logic       b_we = 1'b0, b_re = 1'b0;
  logic [7:0] b_rdata;
  logic       b_pclk, b_ls, b_fs;
  logic [3:0] b_data;

  lcd_scan_fb #(.SCR_W(16), .SCR_H(4)) u_lcd_scan_fb (
    .clk(clk), .rst(rst), .cpu_addr(a_addr), .cpu_wdata(a_wdata), .cpu_we(a_we),
    .cpu_re(a_re), .cpu_rdata(a_rdata), .pclk_o(a_pclk), .data_o(a_data),
    .lsync_o(a_ls), .fsync_o(a_fs));

  lcd_scan_fb #(.SCR_W(4), .SCR_H(3)) u_lcd_scan_fb_narrow (
    .clk(clk), .rst(rst), .cpu_addr(b_addr), .cpu_wdata(b_wdata), .cpu_we(b_we),
    .cpu_re(b_re), .cpu_rdata(b_rdata), .pclk_o(b_pclk), .data_o(b_data),
    .lsync_o(b_ls), .fsync_o(b_fs));

  logic [7:0] ma [ABYTES];
  logic [7:0] mb [BBYTES];
  int tests = 0, fails = 0, pos = 0;

  task automatic chk(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int nib_a(int n);
    return (n % 2) ? int'(ma[n / 2][7:4]) : int'(ma[n / 2][3:0]);
  endfunction

  function automatic int nib_b(int n);
    return (n % 2) ? int'(mb[n / 2][7:4]) : int'(mb[n / 2][3:0]);
  endfunction

  task automatic step(int n);
    repeat (n) begin
      @(posedge clk);
      pos++;
    end
    @(negedge clk);
  endtask

  task automatic scan(int ncyc, string tag, bit en);
    for (int i = 0; i < ncyc; i++) begin
      step(1);
      if (en) begin
        int e = pos - 1;
        int ph = e % 8;
        chk("R2", "pclk", int'(a_pclk), (ph < 4) ? 1 : 0);
        chk("R2", "pclk narrow", int'(b_pclk), (ph < 4) ? 1 : 0);
        if (ph == 2) begin
          int k = e / 8;
          int na = k % ANIB;
          int nb = k % BNIB;
          string dt = (k >= ANIB && na == 0) ? "R5" : tag;
          chk(dt, "data first cycle", int'(a_data), nib_a(na));
          chk("R6", "lsync", int'(a_ls), (na % ACOLS == ACOLS - 1) ? 1 : 0);
          chk("R7", "fsync", int'(a_fs), (na < ACOLS) ? 1 : 0);
          chk("R11", "narrow data", int'(b_data), nib_b(nb));
          chk("R11", "narrow lsync", int'(b_ls), 1);
          chk("R7", "narrow fsync", int'(b_fs), (nb == 0) ? 1 : 0);
        end
        if (ph == 1 && e >= 9) begin
          int k = e / 8 - 1;
          chk(tag, "data last cycle", int'(a_data), nib_a(k % ANIB));
        end
      end
    end
  endtask

  task automatic reset_outputs(string when);
    chk("R1", {when, " pclk"}, int'(a_pclk), 0);
    chk("R1", {when, " data"}, int'(a_data), 0);
    chk("R1", {when, " lsync"}, int'(a_ls), 0);
    chk("R1", {when, " fsync"}, int'(a_fs), 0);
    chk("R1", {when, " rdata"}, int'(a_rdata), 0);
    chk("R1", {when, " narrow pclk"}, int'(b_pclk), 0);
  endtask

  initial begin
    @(negedge clk);
    for (int b = 0; b < ABYTES; b++) begin
      a_addr = 3'(b); a_wdata = 8'((b * 37 + 5) & 255); a_we = 1'b1;
      ma[b] = a_wdata;
      if (b < BBYTES) begin
        b_addr = 1'(b); b_wdata = 8'((b * 91 + 18) & 255); b_we = 1'b1;
        mb[b] = b_wdata;
      end else begin
        b_we = 1'b0;
      end
      step(1);
    end
    a_we = 1'b0; b_we = 1'b0;
    step(2);
    reset_outputs("in reset");

    rst = 1'b0; pos = 0;
    scan(8 * ANIB * 2 + 8, "R3,R4", 1'b1);

    a_addr = 3'd3; a_wdata = 8'hA5; a_we = 1'b1; ma[3] = 8'hA5;
    step(1);
    a_we = 1'b0; a_re = 1'b1;
    step(1);
    chk("R9", "read after write", int'(a_rdata), 8'hA5);
    a_addr = 3'd0;
    step(1);
    chk("R8", "one-cycle read", int'(a_rdata), int'(ma[0]));
    a_re = 1'b0; a_addr = 3'd5;
    step(1);
    chk("R8", "hold without strobe", int'(a_rdata), int'(ma[0]));
    a_addr = 3'd6; a_wdata = 8'h3C; a_we = 1'b1; a_re = 1'b1;
    step(1);
    chk("R9", "read during write", int'(a_rdata), int'(ma[6]));
    ma[6] = 8'h3C; a_we = 1'b0;
    step(1);
    chk("R9", "read new value", int'(a_rdata), 8'h3C);
    a_re = 1'b0;
    a_addr = 3'd1; a_wdata = 8'h96; a_we = 1'b1; ma[1] = 8'h96;
    step(1);
    a_we = 1'b0;

    scan(8 * ANIB + 16, "R10", 1'b0);
    scan(8 * ANIB * 2, "R10", 1'b1);

    rst = 1'b1;
    step(2);
    reset_outputs("mid-run reset");
    rst = 1'b0; pos = 0;
    scan(8 * 5, "R1", 1'b1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 20000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule